// File: doc/BRIEF.md
# Set-Associative Instruction Tag Controller

This block keeps the tags and recency state of a four-way, sixteen-set instruction cache with 16-byte lines. It holds no instruction data. A fetch address sent in one cycle gets a hit or miss answer in the next cycle, together with the way that serves it. On a hit, that is the matching way. On a miss, it is the victim way that has just been refilled with the new tag.

Each way of each set has a small saturating recency counter. On a miss, the victim is the way with the lowest counter. A way mask controls which ways age and which ways may be invalidated. Two control bits gate the block: one says the cache exists and one says it is switched on.

Software drives the block through a narrow register write port. Three command registers each take a line address: one prefetches the line, one drops it, and one is a lock request that is accepted and then discarded. A nonzero value means the command is pending. The block services pending commands one per cycle, but only in cycles with no fetch. It clears each register once it has serviced it.

Top module: `itag_ctrl`

## Requirements
- R1: An address splits into a line offset in bits [3:0], a set index in bits [7:4] and a tag in bits [31:8]. Addresses that differ only in the offset map to the same line.
- R2: When `fetch_valid` is high in a cycle, `resp_valid` is high in the next cycle, with exactly one of the following true:
  - `resp_hit` is high and `resp_way` gives the lowest-numbered way whose tag matches;
  - `resp_miss` is high;
  - the cache is inactive (see R6).
  
  `resp_valid` is low after a cycle without a fetch.
- R3: On a miss, the victim is the way with the smallest counter, with ties going to the lowest-numbered way. The victim's tag is replaced, so a later fetch of that line hits in the way reported as `resp_way`.
- R4: On a miss, the victim's counter becomes 3. Every other way whose counter is nonzero and whose mask bit is set has its counter decreased by one.
- R5: On a hit, the hit way's counter becomes 3. Every other way whose mask bit is set and whose counter is above the hit way's old counter has its counter decreased by one.
- R6: The cache is active only when control bit 0 (present) and control bit 1 (enabled) are both set. While it is inactive, a fetch answers with `resp_valid`=1, `resp_hit`=0, `resp_miss`=0 and `resp_way`=0, and no tag or counter changes.
- R7: An invalidate command marks the matching way invalid (tag all ones) only when that way's mask bit is set. It works with the enable bit clear as long as the present bit is set. If no way matches, or the mask bit is clear, nothing changes.
- R8: The `cfg_sel` codes are as follows:

  | `cfg_sel` | Register |
  |---|---|
  | 0 | control |
  | 1 | way mask, bits [3:0] |
  | 2 | prefetch command |
  | 3 | invalidate command |
  | 4 | lock command |

  `cmd_pending` bits 0, 1 and 2 show whether the prefetch, invalidate and lock registers hold a nonzero value. Writing zero leaves a command not pending. A pending command is serviced in the first cycle without a fetch and its register reads zero afterwards. A write in the same cycle as a service overrides the clear.
- R9: At most one command is serviced per cycle. Prefetch comes first, then invalidate, then lock. Any cycle with `fetch_valid` high services no command.
- R10: A prefetch performs the same lookup and fill as a fetch, following R3–R5 and gated by R6, but produces no response.
- R11: A lock command only clears its register. Tags and counters stay unchanged.
- R12: After reset:
  - all tags are invalid and all counters are zero;
  - present and enabled are set;
  - the way mask is all ones;
  - all command registers are zero;
  - `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch lookup request |
| fetch_addr | input | 32 | Fetch byte address |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select, coded as in R8 |
| cfg_wdata | input | 32 | Register write value |
| resp_valid | output | 1 | Response to the previous cycle's fetch |
| resp_hit | output | 1 | Fetch hit |
| resp_miss | output | 1 | Fetch missed and refilled |
| resp_way | output | 2 | Hit way or refilled way |
| cmd_pending | output | 3 | Nonzero flags of the prefetch, invalidate and lock registers |

## Verification
The checks assume that no fetch or command address carries an all-ones tag, because that value is reserved to mark an invalid way and would otherwise match stale entries. The random stimulus draws tags from 1 to 5 and sets from 0 to 2. This keeps that assumption, forces frequent set conflicts and replacements, and guarantees that every command address is nonzero. Register writes are single-cycle pulses on the select codes listed in R8, and fetches may land in the same cycle as those writes.

// File: rtl/itc_pkg.sv
package itc_pkg;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_MASK = 3'd1;
  localparam logic [2:0] SEL_PF   = 3'd2;
  localparam logic [2:0] SEL_INV  = 3'd3;
  localparam logic [2:0] SEL_LOCK = 3'd4;

  // set index: line number modulo the set count
  function automatic logic [63:0] line_set(input logic [63:0] a, input int off_w,
                                           input int idx_w);
    return (a >> off_w) & ((64'd1 << idx_w) - 64'd1);
  endfunction

  // tag: line number divided by the set count
  function automatic logic [63:0] line_tag(input logic [63:0] a, input int off_w,
                                           input int idx_w);
    return a >> (off_w + idx_w);
  endfunction

endpackage

// File: rtl/itc_cfg_regs.sv
module itc_cfg_regs import itc_pkg::*; #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              svc_pf,
  input  logic              svc_inv,
  input  logic              svc_lock,
  output logic              present,
  output logic              enable,
  output logic [WAYS-1:0]   way_mask,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [ADDR_W-1:0] inv_addr,
  output logic [2:0]        pending
);

  logic [ADDR_W-1:0] lock_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present  <= 1'b1;
      enable   <= 1'b1;
      way_mask <= '1;
    end else if (cfg_wr) begin
      if (cfg_sel == SEL_CTRL) begin
        present <= cfg_wdata[0];
        enable  <= cfg_wdata[1];
      end
      if (cfg_sel == SEL_MASK) way_mask <= cfg_wdata[WAYS-1:0];
    end
  end

  // service clears first; a write in the same cycle wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_addr   <= '0;
      inv_addr  <= '0;
      lock_addr <= '0;
    end else begin
      if (svc_pf)   pf_addr   <= '0;
      if (svc_inv)  inv_addr  <= '0;
      if (svc_lock) lock_addr <= '0;
      if (cfg_wr && cfg_sel == SEL_PF)   pf_addr   <= cfg_wdata;
      if (cfg_wr && cfg_sel == SEL_INV)  inv_addr  <= cfg_wdata;
      if (cfg_wr && cfg_sel == SEL_LOCK) lock_addr <= cfg_wdata;
    end
  end

  assign pending = {|lock_addr, |inv_addr, |pf_addr};

endmodule

// File: rtl/itc_tag_store.sv
module itc_tag_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int TAG_W = 24,
  parameter int CNT_W = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            set_idx,
  input  logic                        tag_we,
  input  logic [WAY_W-1:0]            tag_way,
  input  logic [TAG_W-1:0]            tag_wdata,
  input  logic                        cnt_we,
  input  logic [WAYS-1:0][CNT_W-1:0]  cnt_wdata,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
  output logic [WAYS-1:0][CNT_W-1:0]  rd_cnts
);

  logic [WAYS-1:0][TAG_W-1:0] all_tags [SETS];
  logic [WAYS-1:0][CNT_W-1:0] all_cnts [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0][TAG_W-1:0] tags_r;
    logic [WAYS-1:0][CNT_W-1:0] cnts_r;
    logic sel;
    assign sel = (set_idx == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tags_r <= '1;
        cnts_r <= '0;
      end else begin
        if (tag_we && sel) tags_r[tag_way] <= tag_wdata;
        if (cnt_we && sel) cnts_r <= cnt_wdata;
      end
    end

    assign all_tags[s] = tags_r;
    assign all_cnts[s] = cnts_r;
  end

  assign rd_tags = all_tags[set_idx];
  assign rd_cnts = all_cnts[set_idx];

endmodule

// File: rtl/itc_way_match.sv
module itc_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           tag_in,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);

  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = (tags[w] == tag_in);
  end

  // lowest matching way wins
  always_comb begin
    hit_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) hit_way = WAY_W'(i);
    end
  end

  assign hit = |match;

endmodule

// File: rtl/itc_recency.sv
module itc_recency #(
  parameter int WAYS    = 4,
  parameter int USTATES = 4,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int CNT_W  = $clog2(USTATES)
) (
  input  logic [WAYS-1:0][CNT_W-1:0] cnts,
  input  logic [WAYS-1:0]            mask,
  input  logic                       hit,
  input  logic [WAY_W-1:0]           hit_way,
  output logic [WAY_W-1:0]           victim,
  output logic [WAYS-1:0][CNT_W-1:0] new_cnts
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(USTATES - 1);

  // strictly smaller replaces, so ties keep the lowest way
  always_comb begin
    logic [CNT_W-1:0] least;
    victim = '0;
    least  = cnts[0];
    for (int i = 1; i < WAYS; i++) begin
      if (cnts[i] < least) begin
        least  = cnts[i];
        victim = WAY_W'(i);
      end
    end
  end

  always_comb begin
    logic [CNT_W-1:0] ref_cnt;
    ref_cnt = cnts[hit_way];
    for (int i = 0; i < WAYS; i++) begin
      new_cnts[i] = cnts[i];
      if (hit) begin
        if (WAY_W'(i) == hit_way)
          new_cnts[i] = CNT_MAX;
        else if (mask[i] && cnts[i] > ref_cnt)
          new_cnts[i] = cnts[i] - CNT_W'(1);
      end else begin
        if (WAY_W'(i) == victim)
          new_cnts[i] = CNT_MAX;
        else if (mask[i] && cnts[i] != '0)
          new_cnts[i] = cnts[i] - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/itag_ctrl.sv
module itag_ctrl import itc_pkg::*; #(
  parameter int WAYS        = 4,
  parameter int SETS        = 16,
  parameter int BLOCK_BYTES = 16,
  parameter int USTATES     = 4,
  parameter int ADDR_W      = 32,
  localparam int WAY_W      = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_miss,
  output logic [WAY_W-1:0]  resp_way,
  output logic [2:0]        cmd_pending
);

  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int CNT_W = $clog2(USTATES);

  logic              present, enable, cache_active;
  logic [WAYS-1:0]   way_mask;
  logic [ADDR_W-1:0] pf_addr, inv_addr, op_addr;
  logic              is_pf, is_inv, is_lock, is_fetch;
  logic [IDX_W-1:0]  op_set;
  logic [TAG_W-1:0]  op_tag;

  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0][CNT_W-1:0] set_cnts, next_cnts;
  logic                       hit;
  logic [WAY_W-1:0]           hit_way, victim;

  // named internal events
  logic do_lookup, fill_en, inval_en, cnt_we, tag_we;
  logic [WAY_W-1:0] tag_way;
  logic [TAG_W-1:0] tag_wdata;

  itc_cfg_regs #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .svc_pf(is_pf), .svc_inv(is_inv), .svc_lock(is_lock),
    .present(present), .enable(enable), .way_mask(way_mask),
    .pf_addr(pf_addr), .inv_addr(inv_addr), .pending(cmd_pending)
  );

  // fetch first, then prefetch, invalidate, lock
  always_comb begin
    is_fetch = fetch_valid;
    is_pf    = !fetch_valid && cmd_pending[0];
    is_inv   = !fetch_valid && !cmd_pending[0] && cmd_pending[1];
    is_lock  = !fetch_valid && !cmd_pending[0] && !cmd_pending[1] && cmd_pending[2];
    if (fetch_valid)         op_addr = fetch_addr;
    else if (cmd_pending[0]) op_addr = pf_addr;
    else                     op_addr = inv_addr;
    op_set = IDX_W'(line_set(64'(op_addr), OFF_W, IDX_W));
    op_tag = TAG_W'(line_tag(64'(op_addr), OFF_W, IDX_W));
  end

  itc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .set_idx(op_set),
    .tag_we(tag_we), .tag_way(tag_way), .tag_wdata(tag_wdata),
    .cnt_we(cnt_we), .cnt_wdata(next_cnts),
    .rd_tags(set_tags), .rd_cnts(set_cnts)
  );

  itc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags(set_tags), .tag_in(op_tag), .hit(hit), .hit_way(hit_way)
  );

  itc_recency #(.WAYS(WAYS), .USTATES(USTATES)) u_lru (
    .cnts(set_cnts), .mask(way_mask), .hit(hit), .hit_way(hit_way),
    .victim(victim), .new_cnts(next_cnts)
  );

  always_comb begin
    cache_active = present && enable;
    do_lookup    = (is_fetch || is_pf) && cache_active;
    fill_en      = do_lookup && !hit;
    cnt_we       = do_lookup;
    inval_en     = is_inv && present && hit && way_mask[hit_way];
    tag_we       = fill_en || inval_en;
    tag_way      = fill_en ? victim : hit_way;
    tag_wdata    = fill_en ? op_tag : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_miss  <= 1'b0;
      resp_way   <= '0;
    end else begin
      resp_valid <= fetch_valid;
      resp_hit   <= fetch_valid && cache_active && hit;
      resp_miss  <= fetch_valid && cache_active && !hit;
      resp_way   <= !(fetch_valid && cache_active) ? '0 : (hit ? hit_way : victim);
    end
  end

endmodule

// File: rtl/itag_ctrl_chk.sv
module itag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fetch_valid,
  input logic       cfg_wr,
  input logic [2:0] cfg_sel,
  input logic       resp_valid,
  input logic       resp_hit,
  input logic       resp_miss,
  input logic [2:0] cmd_pending,
  input logic       cache_active,
  input logic       fill_en,
  input logic       inval_en,
  input logic       cnt_we
);

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> resp_valid);

  assert_resp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !resp_valid);

  assert_hit_miss_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_hit && resp_miss));

  assert_bypass_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !cache_active) |=> (!resp_hit && !resp_miss));

  assert_bypass_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cache_active |-> (!fill_en && !cnt_we));

  assert_fill_inval_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && inval_en));

  assert_pf_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && cmd_pending[0] && !(cfg_wr && cfg_sel == 3'd2)) |=> !cmd_pending[0]);

  assert_fetch_holds_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && cmd_pending[0] && !(cfg_wr && cfg_sel == 3'd2)) |=> cmd_pending[0]);

  assert_inv_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pending[0] && cmd_pending[1] && !(cfg_wr && cfg_sel == 3'd3)) |=> cmd_pending[1]);

endmodule

bind itag_ctrl itag_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
  .cmd_pending(cmd_pending), .cache_active(cache_active), .fill_en(fill_en),
  .inval_en(inval_en), .cnt_we(cnt_we)
);

// File: tb/tb_itag_ctrl.sv
module tb_itag_ctrl;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        resp_valid, resp_hit, resp_miss;
  logic [1:0]  resp_way;
  logic [2:0]  cmd_pending;

  int n_tot = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  itag_ctrl dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
    .resp_way(resp_way), .cmd_pending(cmd_pending)
  );

  // reference state
  logic [23:0] m_tag [16][4];
  int          m_cnt [16][4];
  bit          m_present, m_enable;
  logic [3:0]  m_mask;
  logic [31:0] m_pf, m_inv, m_lk;

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int find_way(input logic [31:0] a);
    for (int i = 0; i < 4; i++)
      if (m_tag[a[7:4]][i] == a[31:8]) return i;
    return -1;
  endfunction

  task automatic m_lookup(input logic [31:0] a, output bit eh, output bit em, output int ew);
    int s, w, v, old;
    s = a[7:4];
    eh = 0; em = 0; ew = 0;
    if (!(m_present && m_enable)) return;
    w = find_way(a);
    if (w >= 0) begin
      eh = 1; ew = w; old = m_cnt[s][w];
      for (int i = 0; i < 4; i++)
        if (i != w && m_mask[i] && m_cnt[s][i] > old) m_cnt[s][i]--;
      m_cnt[s][w] = 3;
    end else begin
      em = 1; v = 3;
      for (int i = 3; i >= 0; i--)
        if (m_cnt[s][i] <= m_cnt[s][v]) v = i;
      ew = v;
      m_tag[s][v] = a[31:8];
      for (int i = 0; i < 4; i++)
        if (i != v && m_mask[i] && m_cnt[s][i] != 0) m_cnt[s][i]--;
      m_cnt[s][v] = 3;
    end
  endtask

  task automatic m_invalidate(input logic [31:0] a);
    int w;
    if (!m_present) return;
    w = find_way(a);
    if (w >= 0 && m_mask[w]) m_tag[a[7:4]][w] = '1;
  endtask

  // one clock cycle with optional fetch and optional register write
  task automatic cyc(input bit fv, input logic [31:0] fa, input bit wr, input logic [2:0] sel,
                     input logic [31:0] wd, input string rq);
    bit eh, em, dh, dm;
    int ew, dw;
    fetch_valid = fv; fetch_addr = fa;
    cfg_wr = wr; cfg_sel = sel; cfg_wdata = wd;
    eh = 0; em = 0; ew = 0;
    if (fv) m_lookup(fa, eh, em, ew);
    else if (m_pf != 0) begin m_lookup(m_pf, dh, dm, dw); m_pf = '0; end
    else if (m_inv != 0) begin m_invalidate(m_inv); m_inv = '0; end
    else if (m_lk != 0) m_lk = '0;
    if (wr) begin
      case (sel)
        3'd0: begin m_present = wd[0]; m_enable = wd[1]; end
        3'd1: m_mask = wd[3:0];
        3'd2: m_pf = wd;
        3'd3: m_inv = wd;
        3'd4: m_lk = wd;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    fetch_valid = 1'b0; cfg_wr = 1'b0;
    chk(rq, "resp_valid", 32'(resp_valid), 32'(fv));
    if (fv) begin
      chk(rq, "resp_hit", 32'(resp_hit), 32'(eh));
      chk(rq, "resp_miss", 32'(resp_miss), 32'(em));
      chk(rq, "resp_way", 32'(resp_way), 32'(ew));
    end
    chk("R8", "cmd_pending", 32'(cmd_pending), 32'({m_lk != 0, m_inv != 0, m_pf != 0}));
  endtask

  task automatic fetch(input logic [31:0] a, input string rq);
    cyc(1'b1, a, 1'b0, 3'd0, '0, rq);
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [31:0] d, input string rq);
    cyc(1'b0, '0, 1'b1, sel, d, rq);
  endtask

  task automatic idle(input string rq);
    cyc(1'b0, '0, 1'b0, 3'd0, '0, rq);
  endtask

  function automatic logic [31:0] mk(input int tag, input int set, input int off);
    return {24'(tag), 4'(set), 4'(off)};
  endfunction

  function automatic logic [31:0] rnd_addr();
    return mk(int'($urandom % 5) + 1, int'($urandom % 3), int'($urandom % 16));
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_tot++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd20240611));
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin m_tag[s][w] = '1; m_cnt[s][w] = 0; end
    m_present = 1; m_enable = 1; m_mask = 4'hf;
    m_pf = '0; m_inv = '0; m_lk = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R12", "resp_valid after reset", 32'(resp_valid), 32'd0);
    chk("R12", "cmd_pending after reset", 32'(cmd_pending), 32'd0);

    // R12/R3: empty set fills ways in order 0..3
    fetch(mk(5, 1, 0), "R12");
    chk("R3", "first fill way", 32'(resp_way), 32'd0);
    fetch(mk(5, 1, 12), "R1");               // offset only: same line
    chk("R1", "offset alias hit", 32'(resp_hit), 32'd1);
    fetch(mk(6, 1, 0), "R3");
    chk("R3", "tie goes to lowest way", 32'(resp_way), 32'd1);
    fetch(mk(7, 1, 0), "R3");
    fetch(mk(8, 1, 0), "R4");
    fetch(mk(9, 1, 0), "R4");                // counters 0,1,2,3 -> way 0 replaced
    chk("R4", "oldest replaced", 32'(resp_way), 32'd0);
    fetch(mk(5, 1, 0), "R3");                // evicted line misses
    chk("R3", "evicted line misses", 32'(resp_miss), 32'd1);
    fetch(mk(7, 1, 4), "R5");
    fetch(mk(8, 1, 0), "R5");
    fetch(mk(10, 1, 0), "R4");
    fetch(mk(5, 0, 0), "R1");                // different set, same tag
    chk("R1", "set index separates lines", 32'(resp_miss), 32'd1);

    // R4/R5 with a narrowed way mask
    wreg(3'd1, 32'h1, "R4");
    fetch(mk(11, 1, 0), "R4");
    fetch(mk(12, 1, 0), "R4");
    fetch(mk(7, 1, 0), "R5");
    wreg(3'd1, 32'hf, "R4");

    // R6: inactive cache answers without hit or miss and freezes state
    wreg(3'd0, 32'h1, "R6");
    fetch(mk(20, 2, 0), "R6");
    chk("R6", "bypass no miss", 32'(resp_miss), 32'd0);
    fetch(mk(12, 1, 0), "R6");
    wreg(3'd2, mk(21, 2, 0), "R10");         // prefetch while inactive: no fill
    idle("R10");
    wreg(3'd0, 32'h3, "R6");
    fetch(mk(20, 2, 0), "R6");
    chk("R6", "no fill while inactive", 32'(resp_miss), 32'd1);
    fetch(mk(21, 2, 0), "R10");

    // R7: invalidate with enable clear, present set
    wreg(3'd0, 32'h1, "R7");
    wreg(3'd3, mk(20, 2, 8), "R7");
    idle("R7");
    wreg(3'd0, 32'h3, "R7");
    fetch(mk(20, 2, 0), "R7");
    chk("R7", "invalidated line misses", 32'(resp_miss), 32'd1);
    // R7: masked way cannot be dropped
    wreg(3'd1, 32'(4'hf & ~(4'b1 << find_way(mk(20, 2, 0)))), "R7");
    wreg(3'd3, mk(20, 2, 0), "R7");
    idle("R7");
    wreg(3'd1, 32'hf, "R7");
    fetch(mk(20, 2, 0), "R7");
    chk("R7", "masked way kept", 32'(resp_hit), 32'd1);
    // R7: invalidate of an absent line does nothing
    wreg(3'd3, mk(99, 2, 0), "R7");
    idle("R7");
    fetch(mk(21, 2, 0), "R7");

    // R8: zero write leaves nothing pending
    wreg(3'd2, 32'h0, "R8");
    chk("R8", "zero is not a command", 32'(cmd_pending), 32'd0);

    // R9: fetch blocks service, then prefetch before invalidate
    wreg(3'd2, mk(30, 3, 0), "R9");
    cyc(1'b1, mk(20, 2, 0), 1'b1, 3'd3, mk(20, 2, 0), "R9");
    chk("R9", "both pending after fetch cycle", 32'(cmd_pending), 32'h3);
    idle("R9");
    chk("R9", "prefetch serviced first", 32'(cmd_pending), 32'h2);
    idle("R9");
    fetch(mk(30, 3, 0), "R10");
    chk("R10", "prefetched line hits", 32'(resp_hit), 32'd1);
    fetch(mk(20, 2, 0), "R7");

    // R11: lock only clears
    wreg(3'd4, mk(30, 3, 0), "R11");
    chk("R11", "lock pending", 32'(cmd_pending), 32'h4);
    idle("R11");
    fetch(mk(30, 3, 0), "R11");
    chk("R11", "lock leaves line", 32'(resp_hit), 32'd1);

    // R8: write during service overrides the clear
    wreg(3'd2, mk(31, 3, 0), "R8");
    wreg(3'd2, mk(32, 3, 0), "R8");
    idle("R8");

    // constrained random mix
    for (int k = 0; k < 1500; k++) begin
      r = int'($urandom % 16);
      if (r < 8)       fetch(rnd_addr(), "R2");
      else if (r < 10) wreg(3'd2, rnd_addr(), "R10");
      else if (r < 12) wreg(3'd3, rnd_addr(), "R7");
      else if (r == 12) wreg(3'd4, rnd_addr(), "R11");
      else if (r == 13) wreg(3'd1, $urandom % 16, "R4");
      else if (r == 14) wreg(3'd0, ($urandom % 4 == 0) ? ($urandom % 4) : 3, "R6");
      else             cyc(1'b1, rnd_addr(), 1'b1, 3'(2 + $urandom % 3), rnd_addr(), "R9");
    end

    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

endmodule